// File: doc/BRIEF.md
# Blocked Lookahead Adder

A purely combinational adder of width `WIDTH` that cuts its operands into equal slices of `SLICE` bits. Inside each slice a radix-2 parallel-prefix network folds the per-bit generate and propagate pairs into running group terms. The slices are then joined in one of two ways, fixed at compile time for the whole adder.

In ripple mode the resolved carry of each slice is the carry-in of the next slice. In select mode each slice works out two results in advance, one for each possible incoming carry. The carry that arrives then steers a mux that picks both the sum bits and the outgoing carry. The slice does not build a second copy of its logic for this. The two outgoing carries are the group terms themselves: the group generate G for an incoming 0, and G OR P for an incoming 1.

`SLICE = WIDTH` gives a single prefix network, and `SLICE = 1` gives a bit-serial ripple chain. If `WIDTH` is not a whole multiple of `SLICE`, elaboration stops with an error. The external carry-in enters the least significant slice. The carry-out is the resolved carry leaving the most significant slice.

Top module: `blk_lookahead_adder`

## Requirements
- R1: In ripple mode, {c_out, sum_out} equals a_in + b_in + c_in for every operand pair, for any legal slice size.
- R2: In select mode, {c_out, sum_out} equals a_in + b_in + c_in for every operand pair, for any legal slice size.
- R3: With the slice size equal to the width (one prefix network), the result is still the exact sum in both modes.
- R4: With a slice size of 1 (pure ripple), the result is the exact sum in both modes.
- R5: With both operands zero, sum_out is zero and c_out is 0 when c_in is 0. When c_in is 1, sum_out is 1 and c_out is 0, so c_in enters at bit 0.
- R6: With one operand all ones, the other zero and c_in = 1, the carry runs through every slice: sum_out is all zeros and c_out is 1.
- R7: A carry generated only in the top bit (both operands 1 in bit WIDTH-1, zero elsewhere, c_in = 0) gives sum_out = 0 and c_out = 1.
- R8: A slice whose bits all propagate passes the incoming carry on to the next slice, and a slice that generates sends out a 1 whatever its carry-in. In select mode this matches the outgoing carry being G for carry-in 0 and G OR P for carry-in 1.
- R9: Inside a slice, the group generate and group propagate of any prefix are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into the least significant slice |
| sum_out | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the most significant slice |

## Verification
The bench aims at carries that cross slice boundaries: a full propagate chain from c_in to c_out, a lone generate in the top bit, and carries leaving one slice into a slice that propagates. A design that swapped G and G OR P in select mode, or tied a slice's carry-in to the wrong neighbour, would give wrong bits above the first boundary in exactly these patterns. Four-bit variants are run on every operand pair in both modes with slice sizes 1, 2 and 4, so an off-by-one in the prefix distances shows up at once. Sixteen-bit variants with slices of 1, 4, 8 and 16 take random and directed operands, and a wrong bit 0 carry or a lost top carry would show as a wrong sum_out or c_out.

// File: rtl/blk_add_pkg.sv
package blk_add_pkg;

   // how neighbouring slices are joined
   typedef enum logic {
      JOIN_RIPPLE = 1'b0,
      JOIN_SELECT = 1'b1
   } join_e;

   // merge a more significant (hi) pair with a less significant (lo) pair
   function automatic logic [1:0] gp_merge(input logic [1:0] hi, input logic [1:0] lo);
      logic g_v;
      logic p_v;
      g_v = hi[1] | (hi[0] & lo[1]);
      p_v = hi[0] & lo[0];
      return {g_v, p_v};
   endfunction

endpackage

// File: rtl/prefix_net.sv
module prefix_net #(
   parameter int K = 4
) (
   input  logic [K-1:0] g_in,
   input  logic [K-1:0] p_in,
   output logic [K-1:0] grp_g,   // generate of bits [i:0]
   output logic [K-1:0] grp_p    // propagate of bits [i:0]
);
   localparam int LVL = (K > 1) ? $clog2(K) : 0;

   logic [K-1:0] gt [LVL+1];
   logic [K-1:0] pt [LVL+1];

   assign gt[0] = g_in;
   assign pt[0] = p_in;

   for (genvar s = 0; s < LVL; s++) begin : g_lvl
      localparam int DIST = 1 << s;
      for (genvar i = 0; i < K; i++) begin : g_bit
         if (i >= DIST) begin : g_merge
            logic [1:0] mg;
            assign mg = blk_add_pkg::gp_merge({gt[s][i], pt[s][i]},
                                             {gt[s][i-DIST], pt[s][i-DIST]});
            assign gt[s+1][i] = mg[1];
            assign pt[s+1][i] = mg[0];
         end else begin : g_pass
            assign gt[s+1][i] = gt[s][i];
            assign pt[s+1][i] = pt[s][i];
         end
      end
   end

   assign grp_g = gt[LVL];
   assign grp_p = pt[LVL];

   always_comb begin
      for (int i = 0; i < K; i++) begin
         // R9
         gp_excl_chk: assert (!(grp_g[i] && grp_p[i]))
            else $error("group generate and propagate both set at %0d", i);
      end
   end
endmodule

// File: rtl/blk_slice.sv
module blk_slice #(
   parameter int                 K    = 4,
   parameter blk_add_pkg::join_e JOIN = blk_add_pkg::JOIN_RIPPLE
) (
   input  logic [K-1:0] a,
   input  logic [K-1:0] b,
   input  logic         cin,
   output logic [K-1:0] sum,
   output logic         cout
);
   logic [K-1:0] g_bit;
   logic [K-1:0] p_bit;
   logic [K-1:0] grp_g;
   logic [K-1:0] grp_p;

   assign g_bit = a & b;
   assign p_bit = a ^ b;

   prefix_net #(.K(K)) u_pfx (
      .g_in  (g_bit),
      .p_in  (p_bit),
      .grp_g (grp_g),
      .grp_p (grp_p)
   );

   if (JOIN == blk_add_pkg::JOIN_SELECT) begin : g_sel
      logic [K-1:0] c_if0;
      logic [K-1:0] c_if1;
      logic [K-1:0] sum_if0;
      logic [K-1:0] sum_if1;
      logic         co_if0;
      logic         co_if1;

      for (genvar i = 0; i < K; i++) begin : g_c
         if (i == 0) begin : g_lsb
            assign c_if0[i] = 1'b0;
            assign c_if1[i] = 1'b1;
         end else begin : g_up
            assign c_if0[i] = grp_g[i-1];
            assign c_if1[i] = grp_g[i-1] | grp_p[i-1];
         end
      end

      assign sum_if0 = p_bit ^ c_if0;
      assign sum_if1 = p_bit ^ c_if1;
      assign co_if0  = grp_g[K-1];
      assign co_if1  = grp_g[K-1] | grp_p[K-1];

      assign sum  = cin ? sum_if1 : sum_if0;
      assign cout = cin ? co_if1  : co_if0;

      always_comb begin
         // R2
         sel_step_chk: assert (sum_if1 == K'(sum_if0 + K'(1)))
            else $error("carry-1 sum is not carry-0 sum plus one");
         // R8
         sel_prop_chk: assert (!grp_p[K-1] || ((&sum_if0) && (sum_if1 == '0)))
            else $error("propagating slice gave wrong precomputed sums");
         // R8
         sel_cout_chk: assert ((co_if0 == co_if1) || grp_p[K-1])
            else $error("carry choices differ without slice propagate");
      end
   end else begin : g_rip
      logic [K-1:0] c_in_bit;

      for (genvar i = 0; i < K; i++) begin : g_c
         if (i == 0) begin : g_lsb
            assign c_in_bit[i] = cin;
         end else begin : g_up
            assign c_in_bit[i] = grp_g[i-1] | (grp_p[i-1] & cin);
         end
      end

      assign sum  = p_bit ^ c_in_bit;
      assign cout = grp_g[K-1] | (grp_p[K-1] & cin);

      always_comb begin
         // R1
         rip_slice_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{K{1'b0}}, cin}))
            else $error("ripple slice result differs from operand sum");
      end
   end
endmodule

// File: rtl/blk_lookahead_adder.sv
module blk_lookahead_adder #(
   parameter int                 WIDTH = 16,
   parameter int                 SLICE = 4,
   parameter blk_add_pkg::join_e JOIN  = blk_add_pkg::JOIN_SELECT
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             c_out
);
   localparam int NSLICE = (SLICE > 0) ? WIDTH / SLICE : 1;

   if (SLICE < 1 || WIDTH < 1) begin : g_bad_size
      $error("WIDTH and SLICE must be positive");
   end
   if (SLICE > 0 && (WIDTH % SLICE) != 0) begin : g_bad_div
      $error("WIDTH must be a whole multiple of SLICE");
   end

   logic [NSLICE:0] carry;

   assign carry[0] = c_in;

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      blk_slice #(.K(SLICE), .JOIN(JOIN)) u_slice (
         .a    (a_in[s*SLICE +: SLICE]),
         .b    (b_in[s*SLICE +: SLICE]),
         .cin  (carry[s]),
         .sum  (sum_out[s*SLICE +: SLICE]),
         .cout (carry[s+1])
      );
   end

   assign c_out = carry[NSLICE];

   always_comb begin
      // R1
      total_sum_chk: assert ({c_out, sum_out} ==
                             ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in}))
         else $error("adder result differs from operand sum");
   end
endmodule

// File: tb/tb_blk_lookahead_adder.sv
module tb_blk_lookahead_adder;
   import blk_add_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [15:0] a16 = '0, b16 = '0;
   logic        c16 = 1'b0;
   logic [3:0]  a4 = '0, b4 = '0;
   logic        c4 = 1'b0;

   logic [15:0] s_sel4, s_rip4, s_sel16, s_rip1, s_rip8;
   logic        o_sel4, o_rip4, o_sel16, o_rip1, o_rip8;
   logic [3:0]  s4r2, s4s2, s4s1, s4r4;
   logic        o4r2, o4s2, o4s1, o4r4;

   blk_lookahead_adder #(.WIDTH(16), .SLICE(4),  .JOIN(JOIN_SELECT)) dut
      (.a_in(a16), .b_in(b16), .c_in(c16), .sum_out(s_sel4),  .c_out(o_sel4));
   blk_lookahead_adder #(.WIDTH(16), .SLICE(4),  .JOIN(JOIN_RIPPLE)) d_rip4
      (.a_in(a16), .b_in(b16), .c_in(c16), .sum_out(s_rip4),  .c_out(o_rip4));
   blk_lookahead_adder #(.WIDTH(16), .SLICE(16), .JOIN(JOIN_SELECT)) d_sel16
      (.a_in(a16), .b_in(b16), .c_in(c16), .sum_out(s_sel16), .c_out(o_sel16));
   blk_lookahead_adder #(.WIDTH(16), .SLICE(1),  .JOIN(JOIN_RIPPLE)) d_rip1
      (.a_in(a16), .b_in(b16), .c_in(c16), .sum_out(s_rip1),  .c_out(o_rip1));
   blk_lookahead_adder #(.WIDTH(16), .SLICE(8),  .JOIN(JOIN_RIPPLE)) d_rip8
      (.a_in(a16), .b_in(b16), .c_in(c16), .sum_out(s_rip8),  .c_out(o_rip8));

   blk_lookahead_adder #(.WIDTH(4), .SLICE(2), .JOIN(JOIN_RIPPLE)) d4_r2
      (.a_in(a4), .b_in(b4), .c_in(c4), .sum_out(s4r2), .c_out(o4r2));
   blk_lookahead_adder #(.WIDTH(4), .SLICE(2), .JOIN(JOIN_SELECT)) d4_s2
      (.a_in(a4), .b_in(b4), .c_in(c4), .sum_out(s4s2), .c_out(o4s2));
   blk_lookahead_adder #(.WIDTH(4), .SLICE(1), .JOIN(JOIN_SELECT)) d4_s1
      (.a_in(a4), .b_in(b4), .c_in(c4), .sum_out(s4s1), .c_out(o4s1));
   blk_lookahead_adder #(.WIDTH(4), .SLICE(4), .JOIN(JOIN_RIPPLE)) d4_r4
      (.a_in(a4), .b_in(b4), .c_in(c4), .sum_out(s4r4), .c_out(o4r4));

   task automatic chk(input string req, input string inst,
                      input logic [16:0] got, input logic [16:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h (a=%h b=%h cin=%b)",
                  req, inst, got, exp, a16, b16, c16);
      end
   endtask

   // drive 16-bit operands, sample all 16-bit variants mid-cycle
   task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic c,
                        input logic [16:0] exp, input string req);
      @(posedge clk);
      a16 = a; b16 = b; c16 = c;
      @(negedge clk);
      chk({req, "/R2"}, "sel4",  {o_sel4,  s_sel4},  exp);
      chk({req, "/R1"}, "rip4",  {o_rip4,  s_rip4},  exp);
      chk({req, "/R3"}, "sel16", {o_sel16, s_sel16}, exp);
      chk({req, "/R4"}, "rip1",  {o_rip1,  s_rip1},  exp);
      chk({req, "/R1"}, "rip8",  {o_rip8,  s_rip8},  exp);
   endtask

   task automatic t_zero();   // R5
      run16(16'h0000, 16'h0000, 1'b0, 17'h00000, "R5");
      run16(16'h0000, 16'h0000, 1'b1, 17'h00001, "R5");
   endtask

   task automatic t_chain();  // R6
      run16(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R6");
      run16(16'h0000, 16'hFFFF, 1'b1, 17'h10000, "R6");
   endtask

   task automatic t_top_gen(); // R7
      run16(16'h8000, 16'h8000, 1'b0, 17'h10000, "R7");
   endtask

   task automatic t_boundary(); // R8
      run16(16'h000F, 16'h0000, 1'b1, 17'h00010, "R8");
      run16(16'h0FF0, 16'h0010, 1'b0, 17'h01000, "R8");
      run16(16'h00F8, 16'h0008, 1'b0, 17'h00100, "R8");
      run16(16'h0F0F, 16'h00F1, 1'b0, 17'h01000, "R8");
      run16(16'hF0F0, 16'h0F10, 1'b0, 17'h10000, "R8");
   endtask

   task automatic t_random16(); // R1 R2 R3 R4
      for (int i = 0; i < 400; i++) begin
         logic [15:0] ra, rb;
         logic        rc;
         ra = 16'($urandom);
         rb = 16'($urandom);
         rc = 1'($urandom);
         run16(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0000, rc}, "RND");
      end
   endtask

   task automatic t_exhaustive4(); // R1 R2 R3 R4
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            for (int c = 0; c < 2; c++) begin
               logic [4:0] e;
               @(posedge clk);
               a4 = 4'(x); b4 = 4'(y); c4 = 1'(c);
               e = 5'(x + y + c);
               @(negedge clk);
               chk("R1", "w4k2rip", {12'h000, o4r2, s4r2}, {12'h000, e});
               chk("R2", "w4k2sel", {12'h000, o4s2, s4s2}, {12'h000, e});
               chk("R4", "w4k1sel", {12'h000, o4s1, s4s1}, {12'h000, e});
               chk("R3", "w4k4rip", {12'h000, o4r4, s4r4}, {12'h000, e});
            end
         end
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_zero();
      t_chain();
      t_top_gen();
      t_boundary();
      t_exhaustive4();
      t_random16();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule